// File: doc/BRIEF.md
# Masked Vector Element Sequencer

This block runs one vector instruction at a time over a small register file of integer vectors. After an instruction is accepted, the sequencer feeds one element per clock into a fixed-latency add/subtract pipeline. Each result that is written back is also shown on a writeback port. A length register sets how many leading elements an instruction touches. A mask register, filled by a not-equal compare against a scalar, can stop writeback for individual elements. This is how a loop body with a condition runs as straight-line vector code, and how the short final strip of a long loop is handled.

Instructions arrive on a valid/ready issue port. Each instruction carries an operation code, a destination and two source register numbers, a mask-enable bit and a scalar operand. The scalar is sampled in the acceptance cycle. Back-pressure rule: `in_ready` is high only while no vector instruction is in flight. An offer made while `in_ready` is low is not taken, and the offer may be held or withdrawn freely. The writeback port has no ready signal and cannot be stalled; a consumer must take every cycle in which `wb_valid` is high. `done` pulses once as each instruction retires.

Operation codes on `in_op`: 0 set length, 1 vector+vector add, 2 vector−vector subtract, 3 vector+scalar add, 4 vector−scalar subtract, 5 compare-not-equal to scalar into the mask, 6 and 7 reserved.

Top module: `vseq_top`

## Requirements
- R1: After reset, `in_ready` is 1, `done` and `wb_valid` are 0, `vmask` is all zeros, every element of every vector register is 0, and the length register holds MAXVL.
- R2: Code 0 loads the length register from `in_scalar`. A value of 0 becomes 1, a value above MAXVL becomes MAXVL, and any other value is taken as is. The instruction retires with `done` high in the cycle right after acceptance and produces no writeback.
- R3: Code 1 writes vd[i] = vs1[i] + vs2[i], modulo 2^DW.
- R4: Code 2 writes vd[i] = vs1[i] − vs2[i], modulo 2^DW.
- R5: Codes 3 and 4 write vd[i] = vs1[i] + s and vd[i] = vs1[i] − s respectively, modulo 2^DW, where s is `in_scalar` as sampled at acceptance.
- R6: Code 5 sets `vmask` bit i, for every i below the length, to 1 when vs1[i] differs from the scalar and to 0 otherwise. Mask bits at or above the length keep their value, no vector register is written, and no other code changes the mask.
- R7: With `in_mask_en` = 1, codes 1 to 4 write and report only the elements whose mask bit is 1; all other elements keep their old value. With `in_mask_en` = 0 every element below the length is written. Code 5 ignores `in_mask_en`.
- R8: Elements whose index is at or above the length are never written or reported, whatever their mask bit.
- R9: In unmasked execution, element k appears on the writeback port (`wb_reg`, `wb_idx`, `wb_data`) in the cycle that begins LAT+k rising edges after the acceptance edge. Elements appear in ascending index order, and the register file holds the value from the end of that cycle.
- R10: After acceptance of codes 1 to 5, `in_ready` stays low and offers are ignored until the instruction retires. `done` is high for exactly one cycle, the one that begins LAT+length edges after the acceptance edge, and `in_ready` is high again in that same cycle.
- R11: Codes 6 and 7 are accepted and retire with `done` in the next cycle. They change no register, length or mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, offer will be taken |
| in_op | input | 3 | Operation code |
| in_vd | input | $clog2(NREG) | Destination vector register |
| in_vs1 | input | $clog2(NREG) | First source vector register |
| in_vs2 | input | $clog2(NREG) | Second source vector register |
| in_mask_en | input | 1 | Execute arithmetic under the mask |
| in_scalar | input | DW | Scalar operand or new length |
| done | output | 1 | One-cycle retirement pulse |
| wb_valid | output | 1 | An element is being written back |
| wb_reg | output | $clog2(NREG) | Register being written |
| wb_idx | output | $clog2(MAXVL) | Element index being written |
| wb_data | output | DW | Value written |
| vmask | output | MAXVL | Current mask register, bit i for element i |

## Verification
The bench uses the default build: eight registers of 64 sixteen-bit elements behind a three-stage pipeline. With these values it can run a full 64-element strip, clamp requested lengths of 0 and 200, and produce 16-bit wraparound through subtraction below zero. The three-stage pipeline makes the acceptance-to-writeback and acceptance-to-retire cycle counts distinct and countable. It also uses a length of 8 to show that a compare leaves the upper mask bits alone. Another case shows that an all-zero mask retires an instruction without a single writeback.

// File: rtl/vseq_pkg.sv
`timescale 1ns/1ps
package vseq_pkg;

  typedef enum logic [2:0] {
    VOP_SETLEN = 3'd0,
    VOP_ADD_VV = 3'd1,
    VOP_SUB_VV = 3'd2,
    VOP_ADD_VS = 3'd3,
    VOP_SUB_VS = 3'd4,
    VOP_CMP_NE = 3'd5
  } vop_e;

  // codes that stream elements through the pipeline
  function automatic logic vop_streams(input logic [2:0] op);
    return (op >= 3'(VOP_ADD_VV)) && (op <= 3'(VOP_CMP_NE));
  endfunction

  // second operand comes from the scalar rather than a register
  function automatic logic vop_scalar_b(input logic [2:0] op);
    return (op == 3'(VOP_ADD_VS)) || (op == 3'(VOP_SUB_VS)) ||
           (op == 3'(VOP_CMP_NE));
  endfunction

  function automatic logic vop_is_sub(input logic [2:0] op);
    return (op == 3'(VOP_SUB_VV)) || (op == 3'(VOP_SUB_VS));
  endfunction

endpackage

// File: rtl/vseq_ctrl.sv
`timescale 1ns/1ps
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int MAXVL = 64,
  parameter int NREG  = 8,
  parameter int DW    = 16,
  localparam int IW   = $clog2(MAXVL),
  localparam int LW   = $clog2(MAXVL + 1),
  localparam int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic [RW-1:0] in_vd,
  input  logic [RW-1:0] in_vs1,
  input  logic [RW-1:0] in_vs2,
  input  logic          in_mask_en,
  input  logic [DW-1:0] in_scalar,
  input  logic          retire,
  output logic          feed_valid,
  output logic [IW-1:0] feed_idx,
  output logic          feed_last,
  output logic [2:0]    op_q,
  output logic [RW-1:0] vd_q,
  output logic [RW-1:0] vs1_q,
  output logic [RW-1:0] vs2_q,
  output logic          men_q,
  output logic [DW-1:0] scalar_q,
  output logic          done
);

  logic          busy_q;
  logic          feeding_q;
  logic [LW-1:0] cnt_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] len_next;
  logic          accept;

  assign in_ready = !busy_q;
  assign accept   = in_valid && !busy_q;

  // requested length folded into 1..MAXVL
  always_comb begin
    if (in_scalar == '0)
      len_next = LW'(1);
    else if (in_scalar > DW'(MAXVL))
      len_next = LW'(MAXVL);
    else
      len_next = in_scalar[LW-1:0];
  end

  assign feed_valid = feeding_q;
  assign feed_idx   = cnt_q[IW-1:0];
  assign feed_last  = (cnt_q == (len_q - LW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      feeding_q <= 1'b0;
      cnt_q     <= '0;
      len_q     <= LW'(MAXVL);
      done      <= 1'b0;
      op_q      <= '0;
      vd_q      <= '0;
      vs1_q     <= '0;
      vs2_q     <= '0;
      men_q     <= 1'b0;
      scalar_q  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (vop_streams(in_op)) begin
          busy_q    <= 1'b1;
          feeding_q <= 1'b1;
          cnt_q     <= '0;
          op_q      <= in_op;
          vd_q      <= in_vd;
          vs1_q     <= in_vs1;
          vs2_q     <= in_vs2;
          men_q     <= in_mask_en;
          scalar_q  <= in_scalar;
        end else begin
          done <= 1'b1;
          if (in_op == 3'(VOP_SETLEN))
            len_q <= len_next;
        end
      end
      if (feeding_q) begin
        cnt_q <= cnt_q + LW'(1);
        if (feed_last)
          feeding_q <= 1'b0;
      end
      if (retire) begin
        busy_q <= 1'b0;
        done   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/vseq_vrf.sv
`timescale 1ns/1ps
module vseq_vrf #(
  parameter int NREG  = 8,
  parameter int MAXVL = 64,
  parameter int DW    = 16,
  localparam int IW   = $clog2(MAXVL),
  localparam int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ra_reg,
  input  logic [IW-1:0] ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [RW-1:0] rb_reg,
  input  logic [IW-1:0] rb_idx,
  output logic [DW-1:0] rb_data,
  input  logic          we,
  input  logic [RW-1:0] w_reg,
  input  logic [IW-1:0] w_idx,
  input  logic [DW-1:0] w_data
);

  logic [DW-1:0] mem [NREG][MAXVL];

  assign ra_data = mem[ra_reg][ra_idx];
  assign rb_data = mem[rb_reg][rb_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++)
        for (int e = 0; e < MAXVL; e++)
          mem[r][e] <= '0;
    end else if (we) begin
      mem[w_reg][w_idx] <= w_data;
    end
  end

endmodule

// File: rtl/vseq_alu.sv
`timescale 1ns/1ps
module vseq_alu #(
  parameter int DW  = 16,
  parameter int LAT = 3,
  parameter int TW  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sub,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [TW-1:0] in_tag,
  output logic          out_valid,
  output logic [DW-1:0] out_sum,
  output logic          out_neq,
  output logic [TW-1:0] out_tag
);

  logic [DW-1:0] res0;
  logic          neq0;

  logic [LAT-1:0] pv;
  logic [DW-1:0]  pd [LAT];
  logic [LAT-1:0] pn;
  logic [TW-1:0]  pt [LAT];

  assign res0 = in_sub ? (in_a - in_b) : (in_a + in_b);
  assign neq0 = (in_a != in_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= '0;
      pn <= '0;
      for (int s = 0; s < LAT; s++) begin
        pd[s] <= '0;
        pt[s] <= '0;
      end
    end else begin
      pv[0] <= in_valid;
      pd[0] <= res0;
      pn[0] <= neq0;
      pt[0] <= in_tag;
      for (int s = 1; s < LAT; s++) begin
        pv[s] <= pv[s-1];
        pd[s] <= pd[s-1];
        pn[s] <= pn[s-1];
        pt[s] <= pt[s-1];
      end
    end
  end

  assign out_valid = pv[LAT-1];
  assign out_sum   = pd[LAT-1];
  assign out_neq   = pn[LAT-1];
  assign out_tag   = pt[LAT-1];

endmodule

// File: rtl/vseq_top.sv
`timescale 1ns/1ps
module vseq_top
  import vseq_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int MAXVL = 64,
  parameter int DW    = 16,
  parameter int LAT   = 3,
  localparam int IW   = $clog2(MAXVL),
  localparam int RW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [RW-1:0]    in_vd,
  input  logic [RW-1:0]    in_vs1,
  input  logic [RW-1:0]    in_vs2,
  input  logic             in_mask_en,
  input  logic [DW-1:0]    in_scalar,
  output logic             done,
  output logic             wb_valid,
  output logic [RW-1:0]    wb_reg,
  output logic [IW-1:0]    wb_idx,
  output logic [DW-1:0]    wb_data,
  output logic [MAXVL-1:0] vmask
);

  localparam int TW = 3 + RW + IW;

  logic          feed_valid, feed_last, men_q;
  logic [IW-1:0] feed_idx;
  logic [2:0]    op_q;
  logic [RW-1:0] vd_q, vs1_q, vs2_q;
  logic [DW-1:0] scalar_q;
  logic          retire;

  logic [DW-1:0] ra_data, rb_data, opnd_b;
  logic          is_cmp, elem_en;
  logic [TW-1:0] tag_in, tag_out;

  logic          o_valid, o_neq;
  logic [DW-1:0] o_sum;
  logic          o_cmp, o_en, o_last;
  logic [RW-1:0] o_reg;
  logic [IW-1:0] o_idx;

  logic [MAXVL-1:0] mask_q;

  vseq_ctrl #(.MAXVL(MAXVL), .NREG(NREG), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_vd(in_vd), .in_vs1(in_vs1), .in_vs2(in_vs2),
    .in_mask_en(in_mask_en), .in_scalar(in_scalar),
    .retire(retire),
    .feed_valid(feed_valid), .feed_idx(feed_idx), .feed_last(feed_last),
    .op_q(op_q), .vd_q(vd_q), .vs1_q(vs1_q), .vs2_q(vs2_q),
    .men_q(men_q), .scalar_q(scalar_q), .done(done)
  );

  vseq_vrf #(.NREG(NREG), .MAXVL(MAXVL), .DW(DW)) u_vrf (
    .clk(clk), .rst_n(rst_n),
    .ra_reg(vs1_q), .ra_idx(feed_idx), .ra_data(ra_data),
    .rb_reg(vs2_q), .rb_idx(feed_idx), .rb_data(rb_data),
    .we(wb_valid), .w_reg(o_reg), .w_idx(o_idx), .w_data(o_sum)
  );

  // operand selection and per-element enable at the feed point
  assign is_cmp  = (op_q == 3'(VOP_CMP_NE));
  assign opnd_b  = vop_scalar_b(op_q) ? scalar_q : rb_data;
  assign elem_en = is_cmp || !men_q || mask_q[feed_idx];
  assign tag_in  = {is_cmp, elem_en, feed_last, vd_q, feed_idx};

  vseq_alu #(.DW(DW), .LAT(LAT), .TW(TW)) u_alu (
    .clk(clk), .rst_n(rst_n),
    .in_valid(feed_valid), .in_sub(vop_is_sub(op_q)),
    .in_a(ra_data), .in_b(opnd_b), .in_tag(tag_in),
    .out_valid(o_valid), .out_sum(o_sum), .out_neq(o_neq), .out_tag(tag_out)
  );

  assign {o_cmp, o_en, o_last, o_reg, o_idx} = tag_out;

  assign retire   = o_valid && o_last;
  assign wb_valid = o_valid && o_en && !o_cmp;
  assign wb_reg   = o_reg;
  assign wb_idx   = o_idx;
  assign wb_data  = o_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (o_valid && o_cmp) begin
      for (int e = 0; e < MAXVL; e++)
        if (o_idx == IW'(e))
          mask_q[e] <= o_neq;
    end
  end

  assign vmask = mask_q;

endmodule

// File: rtl/vseq_chk.sv
`timescale 1ns/1ps
module vseq_chk #(
  parameter int MAXVL = 64,
  parameter int DW    = 16,
  localparam int IW   = $clog2(MAXVL),
  localparam int LW   = $clog2(MAXVL + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_op,
  input logic [DW-1:0]    in_scalar,
  input logic             done,
  input logic             wb_valid,
  input logic [IW-1:0]    wb_idx,
  input logic [MAXVL-1:0] vmask
);

  logic          acc;
  logic [LW-1:0] len_seen;
  logic          cmp_open;

  assign acc = in_valid && in_ready;

  // length and compare activity as seen from the issue port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_seen <= LW'(MAXVL);
      cmp_open <= 1'b0;
    end else begin
      if (acc && in_op == 3'd0) begin
        if (in_scalar == '0)              len_seen <= LW'(1);
        else if (in_scalar > DW'(MAXVL))  len_seen <= LW'(MAXVL);
        else                              len_seen <= in_scalar[LW-1:0];
      end
      if (acc && in_op == 3'd5)  cmp_open <= 1'b1;
      else if (done)             cmp_open <= 1'b0;
    end
  end

  assert_len_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (LW'(wb_idx) < len_seen));

  assert_ascending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && $past(wb_valid)) |-> (wb_idx > $past(wb_idx)));

  assert_busy_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op >= 3'd1 && in_op <= 3'd5) |=> !in_ready);

  assert_wb_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !in_ready);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !acc) |=> !done);

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_open && !(acc && in_op == 3'd5)) |=> $stable(vmask));

endmodule

bind vseq_top vseq_chk #(.MAXVL(MAXVL), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_scalar(in_scalar), .done(done), .wb_valid(wb_valid),
  .wb_idx(wb_idx), .vmask(vmask)
);

// File: tb/sim_vseq_top.sv
`timescale 1ns/1ps
module sim_vseq_top;

  localparam int NREG = 8, MAXVL = 64, DW = 16, LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_op = '0;
  logic [2:0] in_vd = '0, in_vs1 = '0, in_vs2 = '0;
  logic in_mask_en = 1'b0;
  logic [15:0] in_scalar = '0;
  logic done, wb_valid;
  logic [2:0] wb_reg;
  logic [5:0] wb_idx;
  logic [15:0] wb_data;
  logic [63:0] vmask;

  always #4 clk = ~clk;  // 125 MHz

  vseq_top #(.NREG(NREG), .MAXVL(MAXVL), .DW(DW), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_vd(in_vd), .in_vs1(in_vs1), .in_vs2(in_vs2),
    .in_mask_en(in_mask_en), .in_scalar(in_scalar), .done(done),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_idx(wb_idx),
    .wb_data(wb_data), .vmask(vmask)
  );

  typedef struct {
    int    rg;
    int    idx;
    int    data;
    int    cyc;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  int mreg [8][64];
  int mlen = 64;
  bit mmask [64];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // scoreboard monitor
  exp_t e;
  always @(negedge clk) begin
    if (rst_n && wb_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8 unexpected writeback", longint'(wb_idx), -1);
      end else begin
        e = exp_q.pop_front();
        chk(int'(wb_reg) == e.rg && int'(wb_idx) == e.idx && int'(wb_data) == e.data,
            e.req, {wb_reg, wb_idx, wb_data}, {e.rg[2:0], e.idx[5:0], e.data[15:0]});
        if (e.cyc >= 0)
          chk(cyc == e.cyc, "R9 writeback cycle", cyc, e.cyc);
      end
    end
  end

  // drive one instruction; returns the cycle number read just after acceptance
  task automatic start_op(input int op, input int vd, input int vs1, input int vs2,
                          input bit men, input int sc, input string req, output int a);
    int nv [64];
    @(negedge clk);
    in_valid = 1'b1; in_op = op[2:0]; in_vd = vd[2:0]; in_vs1 = vs1[2:0];
    in_vs2 = vs2[2:0]; in_mask_en = men; in_scalar = sc[15:0];
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    a = cyc;
    if (op == 0) begin
      mlen = (sc == 0) ? 1 : ((sc > 64) ? 64 : sc);
    end else if (op >= 1 && op <= 4) begin
      for (int k = 0; k < 64; k++) nv[k] = mreg[vd][k];
      for (int k = 0; k < mlen; k++) begin
        if (!men || mmask[k]) begin
          int b, r;
          b = (op == 1 || op == 2) ? mreg[vs2][k] : (sc & 16'hFFFF);
          r = (op == 1 || op == 3) ? (mreg[vs1][k] + b) : (mreg[vs1][k] - b);
          r = r & 16'hFFFF;
          nv[k] = r;
          exp_q.push_back('{vd, k, r, men ? -1 : a + LAT + k, req});
        end
      end
      for (int k = 0; k < 64; k++) mreg[vd][k] = nv[k];
    end else if (op == 5) begin
      for (int k = 0; k < mlen; k++) mmask[k] = (mreg[vs1][k] != (sc & 16'hFFFF));
    end
  endtask

  task automatic finish_op(input int op, input int a, input int len_used, input string req);
    int edone;
    edone = (op >= 1 && op <= 5) ? a + LAT + len_used : a;
    while (!done && cyc < a + 400) @(negedge clk);
    chk(cyc == edone, "R10 done cycle", cyc, edone);
    chk(in_ready == 1'b1, "R10 ready at retire", in_ready, 1);
    chk(exp_q.size() == 0, {req, " all writebacks seen"}, exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    chk(done == 1'b0, "R10 done lasts one cycle", done, 0);
  endtask

  task automatic issue(input int op, input int vd, input int vs1, input int vs2,
                       input bit men, input int sc, input string req);
    int a, l;
    l = mlen;
    start_op(op, vd, vs1, vs2, men, sc, req, a);
    finish_op(op, a, l, req);
  endtask

  task automatic check_mask(input string req);
    logic [63:0] em;
    for (int k = 0; k < 64; k++) em[k] = mmask[k];
    chk(vmask == em, req, vmask, em);
  endtask

  initial begin
    int a;
    for (int r = 0; r < 8; r++) for (int k = 0; k < 64; k++) mreg[r][k] = 0;
    for (int k = 0; k < 64; k++) mmask[k] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    chk(done == 1'b0 && wb_valid == 1'b0, "R1 quiet after reset", {done, wb_valid}, 0);
    chk(vmask == '0, "R1 mask cleared", vmask, 0);
    rst_n = 1'b1;

    // R1 R5 R9: full default length, zero register plus scalar
    issue(3, 1, 0, 0, 0, 7, "R5 add scalar full length");
    // R2 short strip, R8 upper elements untouched
    issue(0, 0, 0, 0, 0, 5, "R2 set length 5");
    issue(3, 1, 1, 0, 0, 3, "R8 short strip add");
    // R2 clamp low
    issue(0, 0, 0, 0, 0, 0, "R2 length 0 clamps to 1");
    issue(3, 2, 1, 0, 0, 1, "R2 one element");
    // R2 clamp high
    issue(0, 0, 0, 0, 0, 200, "R2 length 200 clamps to max");
    issue(1, 3, 1, 2, 0, 0, "R3 vector add");
    issue(2, 4, 1, 3, 0, 0, "R4 vector subtract wraps");
    issue(4, 5, 1, 0, 0, 10, "R5 subtract scalar");
    // R6 compare at full length
    issue(5, 0, 5, 0, 1, 0, "R6 compare full");
    check_mask("R6 mask after full compare");
    // R6 compare under short length keeps upper bits
    issue(0, 0, 0, 0, 0, 8, "R2 set length 8");
    issue(5, 0, 1, 0, 0, 10, "R6 compare short");
    check_mask("R6 upper mask bits kept");
    // R7 masked add, then unmasked copy shows kept elements
    issue(3, 1, 1, 0, 1, 100, "R7 masked add");
    issue(0, 0, 0, 0, 0, 64, "R2 set length 64");
    issue(1, 6, 1, 0, 0, 0, "R7 unmasked copy shows kept values");
    check_mask("R6 arithmetic leaves mask");
    // R7 all-zero mask: no writeback at all
    issue(5, 0, 0, 0, 0, 0, "R6 compare gives zero mask");
    check_mask("R6 zero mask");
    issue(2, 6, 6, 6, 1, 0, "R7 zero mask writes nothing");
    issue(1, 7, 6, 0, 0, 0, "R7 values kept after zero mask");
    // R10 back-pressure: offer during busy is ignored
    issue(0, 0, 0, 0, 0, 4, "R2 set length 4");
    start_op(3, 7, 0, 0, 0, 5, "R10 add while offer held", a);
    in_valid = 1'b1; in_op = 3'd0; in_scalar = 16'd2;
    chk(in_ready == 1'b0, "R10 busy refuses", in_ready, 0);
    @(negedge clk);
    chk(in_ready == 1'b0, "R10 busy refuses", in_ready, 0);
    in_valid = 1'b0;
    finish_op(3, a, 4, "R10 add while offer held");
    issue(1, 6, 7, 7, 0, 0, "R10 length unchanged by refused offer");
    // R11 reserved codes
    issue(7, 3, 1, 2, 0, 9, "R11 reserved 7");
    issue(6, 3, 1, 2, 1, 9, "R11 reserved 6");
    check_mask("R11 mask unchanged");
    issue(1, 6, 7, 7, 0, 0, "R11 length unchanged");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R10 run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule